// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog timer that runs on a slow clock and steps through four timeout stages in a fixed order, 0, 1, 2, 3, and then back to 0. Each stage has its own hold count and its own action on expiry. The action can be to do nothing, to raise an interrupt, to pulse a CPU reset, to pulse a system reset, or to pulse a reset of the always-on (RTC) domain. Software keeps the sequence in stage 0 by writing the feed register before stage 0 runs out. When it stops feeding, the consequences escalate one stage at a time.

Software reaches the block through a small synchronous register port. The control and hold registers are locked until a 32-bit key is written. A boot mode bit is set out of reset and keeps the timer running even while the enable bit is clear. An optional pause stops counting while the sleep input is high. The stage 0 hold is scaled by a factor that a fuse input selects. The reset outputs are pulses whose lengths are given in nanoseconds by 3-bit codes and converted to whole slow-clock cycles.

Top module: `stage_watchdog`

## Requirements
- R1: The control register (address 0) and the hold registers (addresses 1 to 4, for stages 0 to 3) accept writes only while the block is unlocked. A write of 0x50D83AA1 to the key register (address 6) unlocks the block. A write of any other value to that register locks it again. Reading address 6 returns the unlock state in bit 0. A write made while locked leaves the register's read-back value unchanged.
- R2: Each time the current stage expires, the block carries out that stage's action and moves to the next stage with its count cleared. After stage 3 it returns to stage 0. The action field of stage s is in control bits [13+3s:11+3s]. The action codes are 0 = none, 1 = interrupt, 2 = CPU reset, 3 = system reset, 4 = RTC-domain reset. Action 0 drives no output.
- R3: Stage 0 expires after hold0 << (1 + prescale_sel) running cycles. Stages 1 to 3 expire after exactly their hold value, with no scaling.
- R4: A write to the feed register (address 5) with bit 0 set clears the count and returns the sequence to stage 0. This register is not subject to the lock. Expiry then follows the full stage 0 limit counted from the feed.
- R5: The timer counts only while control bit 0 (enable) or control bit 1 (boot mode) is set. With both bits clear, no stage ever expires.
- R6: While control bit 2 (pause in sleep) is set and sleep_req is high, the count is frozen. When sleep_req falls, counting resumes from the frozen value. When bit 2 is clear, sleep_req has no effect.
- R7: A stage expiry with action 1 sets the interrupt status (read at address 8, bit 0). Writing 1 to bit 0 of address 9 clears the status. irq equals the status ANDed with the enable bit at address 7, bit 0. A write of 0 to address 9 leaves the status set.
- R8: A CPU-reset action pulses cpu0_rst only if control bit 3 is set, and pulses cpu1_rst only if control bit 4 is set.
- R9: A reset pulse starts in the cycle after the expiry edge. It lasts ceil(T/CLK_NS) cycles, with a minimum of 1 cycle. T in ns is 100, 200, 300, 400, 500, 800, 1600 or 3200 for codes 0 to 7. The CPU code is in control bits [7:5] and the system code is in bits [10:8].
- R10: The system-reset action pulses sys_rst and the RTC-domain action pulses rtc_rst. Both pulses use the system length code.
- R11: After reset, all outputs are low and the interrupt status and enable are 0. The block is locked and the control register reads 0x1A: boot mode set, both CPU reset enables set, and everything else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| prescale_sel | input | 2 | Fuse-selected stage 0 scale exponent |
| sleep_req | input | 1 | Sleep indication |
| irq | output | 1 | Watchdog interrupt |
| cpu0_rst | output | 1 | CPU 0 reset pulse |
| cpu1_rst | output | 1 | CPU 1 reset pulse |
| sys_rst | output | 1 | System reset pulse |
| rtc_rst | output | 1 | RTC-domain reset pulse |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. A locked write never changes the control register. A feed always returns the count and the stage to zero. An expiry advances the stage by exactly one. The count holds while the timer is idle or paused. A clear removes the interrupt status, and a reset pulse starts the cycle after its trigger and ends when its counter runs out. Other behaviour is only visible at the ports over many cycles, so the bench's scenarios show it. That covers the exact expiry cycle for each prescale choice, the order of actions across a full escalation and its wrap to stage 0, the pulse length for each code, and the routing between the two CPUs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned NSTG = 4;
  localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_HOLD0 = 4'd1;
  localparam logic [3:0] A_FEED  = 4'd5;
  localparam logic [3:0] A_KEY   = 4'd6;
  localparam logic [3:0] A_IEN   = 4'd7;
  localparam logic [3:0] A_IST   = 4'd8;
  localparam logic [3:0] A_ICLR  = 4'd9;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_RTC  = 3'd4
  } wd_act_e;

  typedef struct packed {
    logic [NSTG-1:0][2:0] act;
    logic [2:0] sys_len;
    logic [2:0] cpu_len;
    logic       cpu1_en;
    logic       cpu0_en;
    logic       pause_en;
    logic       boot_mode;
    logic       enable;
  } wd_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wd_ctrl_t);

  // Pulse length in ns for each 3-bit code.
  function automatic int unsigned pulse_ns(input logic [2:0] code);
    int unsigned r;
    case (code)
      3'd0: r = 100;
      3'd1: r = 200;
      3'd2: r = 300;
      3'd3: r = 400;
      3'd4: r = 500;
      3'd5: r = 800;
      3'd6: r = 1600;
      default: r = 3200;
    endcase
    return r;
  endfunction

  // Whole slow-clock cycles, rounded up, never below one.
  function automatic int unsigned pulse_cycles(input logic [2:0] code, input int unsigned clk_ns);
    int unsigned c;
    c = (pulse_ns(code) + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned       HOLD_W   = 16,
  parameter logic              BOOT_RST = 1'b1,
  parameter logic [HOLD_W-1:0] HOLD_RST = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [3:0]                  addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output wd_ctrl_t                    ctrl,
  output logic [NSTG-1:0][HOLD_W-1:0] hold,
  output logic                        feed,
  input  logic                        int_set,
  output logic                        int_st,
  output logic                        int_en
);
  localparam wd_ctrl_t CTRL_RST = '{act: '0, sys_len: 3'd0, cpu_len: 3'd0,
                                    cpu1_en: 1'b1, cpu0_en: 1'b1, pause_en: 1'b0,
                                    boot_mode: BOOT_RST, enable: 1'b0};

  logic unlocked;
  logic wr_ok;
  logic clr_req;

  assign wr_ok   = we && unlocked;
  assign feed    = we && (addr == A_FEED) && wdata[0];
  assign clr_req = we && (addr == A_ICLR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl     <= CTRL_RST;
      int_en   <= 1'b0;
      int_st   <= 1'b0;
      for (int i = 0; i < NSTG; i++) hold[i] <= HOLD_RST;
    end else begin
      if (we && addr == A_KEY) unlocked <= (wdata == UNLOCK_KEY);
      if (wr_ok && addr == A_CTRL) ctrl <= wd_ctrl_t'(wdata[CTRL_W-1:0]);
      for (int i = 0; i < NSTG; i++)
        if (wr_ok && addr == A_HOLD0 + 4'(i)) hold[i] <= wdata[HOLD_W-1:0];
      if (we && addr == A_IEN) int_en <= wdata[0];
      if (int_set)      int_st <= 1'b1;
      else if (clr_req) int_st <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl;
      A_KEY:   rdata[0] = unlocked;
      A_IEN:   rdata[0] = int_en;
      A_IST:   rdata[0] = int_st;
      default: ;
    endcase
    for (int i = 0; i < NSTG; i++)
      if (addr == A_HOLD0 + 4'(i)) rdata[HOLD_W-1:0] = hold[i];
  end

  // R1
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CTRL && !unlocked) |=> $stable(ctrl));
  // R7
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !int_set) |=> !int_st);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_NS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic [2:0] len,
  output logic       pulse
);
  localparam int unsigned MAX_CYC = pulse_cycles(3'd7, CLK_NS);
  localparam int unsigned PW      = $clog2(MAX_CYC + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (trig)          left <= PW'(pulse_cycles(len, CLK_NS));
    else if (left != '0)    left <= left - PW'(1);
  end

  assign pulse = (left != '0);

  // R9
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);
  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && left == PW'(1)) |=> !pulse);
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int unsigned HOLD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        boot,
  input  logic                        pause_en,
  input  logic [NSTG-1:0][2:0]        act,
  input  logic [NSTG-1:0][HOLD_W-1:0] hold,
  input  logic [1:0]                  pre_sel,
  input  logic                        sleep,
  input  logic                        feed,
  output logic                        fire_irq,
  output logic                        fire_cpu,
  output logic                        fire_sys,
  output logic                        fire_rtc
);
  localparam int unsigned CNT_W = HOLD_W + 5;

  function automatic logic [CNT_W-1:0] limit_of(input logic [1:0] stg,
                                                input logic [HOLD_W-1:0] h,
                                                input logic [1:0] sel);
    logic [CNT_W-1:0] w;
    w = CNT_W'(h);
    if (stg == 2'd0) w = w << ({1'b0, sel} + 3'd1);
    return w;
  endfunction

  logic [CNT_W-1:0] count;
  logic [1:0]       stage;
  logic             run;
  logic             expire;
  logic [CNT_W-1:0] limit;
  logic [2:0]       cur_act;

  assign run     = (en || boot) && !(pause_en && sleep);
  assign limit   = limit_of(stage, hold[stage], pre_sel);
  assign expire  = run && ((count + CNT_W'(1)) >= limit);
  assign cur_act = act[stage];

  assign fire_irq = expire && (cur_act == ACT_IRQ);
  assign fire_cpu = expire && (cur_act == ACT_CPU);
  assign fire_sys = expire && (cur_act == ACT_SYS);
  assign fire_rtc = expire && (cur_act == ACT_RTC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      stage <= '0;
    end else if (feed) begin
      count <= '0;
      stage <= '0;
    end else if (expire) begin
      count <= '0;
      stage <= stage + 2'd1;
    end else if (run) begin
      count <= count + CNT_W'(1);
    end
  end

  // R4
  feed_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (stage == 2'd0 && count == '0));
  // R2
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !feed) |=> (stage == $past(stage) + 2'd1 && count == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !boot && !feed) |=> ($stable(count) && $stable(stage)));
  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && sleep && !feed) |=> ($stable(count) && $stable(stage)));
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned       HOLD_W   = 16,
  parameter int unsigned       CLK_NS   = 100,
  parameter logic              BOOT_RST = 1'b1,
  parameter logic [HOLD_W-1:0] HOLD_RST = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  prescale_sel,
  input  logic        sleep_req,
  output logic        irq,
  output logic        cpu0_rst,
  output logic        cpu1_rst,
  output logic        sys_rst,
  output logic        rtc_rst
);
  wd_ctrl_t                    ctrl;
  logic [NSTG-1:0][HOLD_W-1:0] hold;
  logic                        feed, int_st, int_en;
  logic                        fire_irq, fire_cpu, fire_sys, fire_rtc;
  logic [3:0]                  ch_trig, ch_out;
  logic [3:0][2:0]             ch_len;

  wdog_regs #(.HOLD_W(HOLD_W), .BOOT_RST(BOOT_RST), .HOLD_RST(HOLD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(ctrl), .hold(hold), .feed(feed),
    .int_set(fire_irq), .int_st(int_st), .int_en(int_en));

  wdog_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .boot(ctrl.boot_mode),
    .pause_en(ctrl.pause_en), .act(ctrl.act), .hold(hold), .pre_sel(prescale_sel),
    .sleep(sleep_req), .feed(feed), .fire_irq(fire_irq), .fire_cpu(fire_cpu),
    .fire_sys(fire_sys), .fire_rtc(fire_rtc));

  // Channel 0/1: the two CPUs, 2: system, 3: RTC domain.
  assign ch_trig = {fire_rtc, fire_sys, fire_cpu && ctrl.cpu1_en, fire_cpu && ctrl.cpu0_en};
  assign ch_len  = {ctrl.sys_len, ctrl.sys_len, ctrl.cpu_len, ctrl.cpu_len};

  for (genvar c = 0; c < 4; c++) begin : g_rst
    wdog_pulse #(.CLK_NS(CLK_NS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(ch_trig[c]), .len(ch_len[c]), .pulse(ch_out[c]));
  end

  assign cpu0_rst = ch_out[0];
  assign cpu1_rst = ch_out[1];
  assign sys_rst  = ch_out[2];
  assign rtc_rst  = ch_out[3];
  assign irq      = int_st && int_en;

  // R8
  cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_cpu && !ctrl.cpu0_en && !cpu0_rst) |=> !cpu0_rst);
endmodule

// File: tb/test_stage_watchdog.sv
`timescale 1ns/1ps
module test_stage_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  prescale_sel = 2'd0;
  logic        sleep_req = 1'b0;
  logic        irq, cpu0_rst, cpu1_rst, sys_rst, rtc_rst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stage_watchdog i_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prescale_sel(prescale_sel),
    .sleep_req(sleep_req), .irq(irq), .cpu0_rst(cpu0_rst), .cpu1_rst(cpu1_rst),
    .sys_rst(sys_rst), .rtc_rst(rtc_rst));

  localparam logic [31:0] KEY = 32'h50D8_3AA1;
  // {hold0, prescale_sel, expected stage 0 limit}
  localparam logic [23:0] VEC [5] = '{
    {16'd3, 2'd0, 6'd6}, {16'd2, 2'd1, 6'd8}, {16'd1, 2'd2, 6'd8},
    {16'd1, 2'd3, 6'd16}, {16'd5, 2'd0, 6'd10}};

  function automatic logic [31:0] mk(input bit en, boot, pz, c0, c1,
                                     input logic [2:0] cl, sl, a0, a1, a2, a3);
    return {9'd0, a3, a2, a1, a0, sl, cl, c1, c0, pz, boot, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Stops the timer, sets the holds, clears and enables the interrupt, then feeds.
  task automatic prep(input logic [15:0] h0, h1, h2, h3);
    wr(4'd0, 32'd0);
    wr(4'd1, {16'd0, h0}); wr(4'd2, {16'd0, h1});
    wr(4'd3, {16'd0, h2}); wr(4'd4, {16'd0, h3});
    wr(4'd9, 32'd1); wr(4'd7, 32'd1); wr(4'd5, 32'd1);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 resets", {28'd0, cpu0_rst, cpu1_rst, sys_rst, rtc_rst}, 0);
    rd(4'd0, d); chk("R11 ctrl", d, 32'h1A);
    rd(4'd8, d); chk("R11 status", d, 0);

    // R1 write lock
    rd(4'd6, d); chk("R1 locked", d, 0);
    wr(4'd0, 32'h1); rd(4'd0, d); chk("R1 locked ctrl", d, 32'h1A);
    wr(4'd2, 32'h55); rd(4'd2, d); chk("R1 locked hold", d, 32'hFFFF);
    wr(4'd6, KEY ^ 32'h1); rd(4'd6, d); chk("R1 near key", d, 0);
    wr(4'd6, KEY); rd(4'd6, d); chk("R1 unlocked", d, 1);
    wr(4'd0, 32'h0); rd(4'd0, d); chk("R1 ctrl write", d, 0);
    wr(4'd6, 32'h0); rd(4'd6, d); chk("R1 relocked", d, 0);
    wr(4'd0, 32'h5); rd(4'd0, d); chk("R1 relocked ctrl", d, 0);
    wr(4'd6, KEY);

    // R3 stage 0 scaling, table driven
    for (int v = 0; v < 5; v++) begin
      prep(VEC[v][23:8], 16'd1000, 16'd1000, 16'd1000);
      prescale_sel = VEC[v][7:6];
      wr(4'd0, mk(1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0));
      step(int'(VEC[v][5:0]) - 1);
      chk($sformatf("R3 vec%0d early", v), {31'd0, irq}, 0);
      step(1);
      chk($sformatf("R3 vec%0d expiry", v), {31'd0, irq}, 1);
    end
    prescale_sel = 2'd0;

    // R2 R8 R10 escalation and wrap
    prep(16'd1, 16'd3, 16'd4, 16'd2);
    wr(4'd0, mk(1, 0, 0, 1, 0, 2, 1, 1, 2, 3, 4));
    for (int e = 1; e <= 18; e++) begin
      step(1);
      chk($sformatf("R2 irq e%0d", e), {31'd0, irq}, (e >= 2) ? 1 : 0);
      chk($sformatf("R2 cpu0 e%0d", e), {31'd0, cpu0_rst},
          ((e >= 5 && e <= 7) || (e >= 16 && e <= 18)) ? 1 : 0);
      chk($sformatf("R8 cpu1 e%0d", e), {31'd0, cpu1_rst}, 0);
      chk($sformatf("R10 sys e%0d", e), {31'd0, sys_rst}, (e == 9 || e == 10) ? 1 : 0);
      chk($sformatf("R10 rtc e%0d", e), {31'd0, rtc_rst}, (e == 11 || e == 12) ? 1 : 0);
    end

    // R9 pulse lengths: codes 0, 5, 7 give 1, 8, 32 cycles at 100 ns
    for (int k = 0; k < 3; k++) begin
      logic [2:0] code;
      int cyc;
      code = (k == 0) ? 3'd0 : (k == 1) ? 3'd5 : 3'd7;
      cyc  = (k == 0) ? 1 : (k == 1) ? 8 : 32;
      prep(16'd1, 16'd1000, 16'd1000, 16'd1000);
      wr(4'd0, mk(1, 0, 0, 1, 1, code, 0, 2, 0, 0, 0));
      step(1); chk($sformatf("R9 code%0d before", code), {31'd0, cpu0_rst}, 0);
      step(1); chk($sformatf("R9 code%0d start", code), {30'd0, cpu0_rst, cpu1_rst}, 3);
      step(cyc - 1); chk($sformatf("R9 code%0d last", code), {31'd0, cpu0_rst}, 1);
      step(1); chk($sformatf("R9 code%0d end", code), {31'd0, cpu0_rst}, 0);
    end

    // R8 routing to CPU 1 only
    prep(16'd1, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(1, 0, 0, 0, 1, 0, 0, 2, 0, 0, 0));
    step(2);
    chk("R8 cpu0 gated", {31'd0, cpu0_rst}, 0);
    chk("R8 cpu1 pulsed", {31'd0, cpu1_rst}, 1);

    // R4 feeding keeps stage 0 alive
    prep(16'd3, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    for (int f = 0; f < 5; f++) begin
      step(3);
      wr(4'd5, 32'd1);
    end
    chk("R4 fed", {31'd0, irq}, 0);
    step(5); chk("R4 after feed early", {31'd0, irq}, 0);
    step(1); chk("R4 after feed expiry", {31'd0, irq}, 1);

    // R5 boot mode runs while enable is clear
    prep(16'd3, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(0, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    step(5); chk("R5 boot early", {31'd0, irq}, 0);
    step(1); chk("R5 boot expiry", {31'd0, irq}, 1);
    prep(16'd3, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(0, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    step(40); chk("R5 both off", {31'd0, irq}, 0);

    // R6 pause in sleep
    sleep_req = 1'b1;
    prep(16'd3, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(1, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0));
    step(30); chk("R6 paused", {31'd0, irq}, 0);
    sleep_req = 1'b0;
    step(5); chk("R6 resumed early", {31'd0, irq}, 0);
    step(1); chk("R6 resumed expiry", {31'd0, irq}, 1);
    sleep_req = 1'b1;
    prep(16'd3, 16'd1000, 16'd1000, 16'd1000);
    wr(4'd0, mk(1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0));
    step(5); chk("R6 no pause early", {31'd0, irq}, 0);
    step(1); chk("R6 no pause expiry", {31'd0, irq}, 1);
    sleep_req = 1'b0;

    // R7 interrupt enable, status and clear
    wr(4'd7, 32'd0);
    chk("R7 masked irq", {31'd0, irq}, 0);
    rd(4'd8, d); chk("R7 status kept", d, 1);
    wr(4'd9, 32'd0); rd(4'd8, d); chk("R7 zero write", d, 1);
    wr(4'd9, 32'd1); rd(4'd8, d); chk("R7 cleared", d, 0);
    wr(4'd7, 32'd1);
    chk("R7 irq after clear", {31'd0, irq}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule